// File: doc/BRIEF.md
# Single-to-Half Precision Float Converter

The block narrows a 32-bit IEEE binary32 word into a 16-bit IEEE binary16 word. Each cycle with `in_valid` high, one input word is accepted. The converted word appears on `out_data`, with `out_valid` set, exactly one clock later. Back-to-back inputs are accepted with no gaps.

A one-bit mode input picks the rounding rule for each word. Mode 0 rounds half-up on the magnitude. Mode 1 rounds to nearest and breaks ties toward an even result.

All classes of input are handled:
- signed zero and binary32 subnormals, both of which flush to zero;
- values too large for the half format, which become infinity;
- values too small to be half normals, which become half subnormals or zero;
- infinity and NaN.

Every NaN leaves as a single quiet pattern with its sign kept. A rounding carry is allowed to run from the mantissa into the exponent field.

Top module: `fp32_to_fp16_cvt`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous cycle. `out_data` loads only on a valid input and holds its value otherwise. A synchronous active-low reset clears both outputs to 0.
- R2: Output bit 15 is a copy of input bit 31 for every input, including zero, infinity and NaN.
- R3: An input exponent field (bits 30:23) of 0 gives an output magnitude (bits 14:0) of 0, whatever the input mantissa.
- R4: An input exponent field of 255 gives magnitude 0x7C00 when input bits 22:0 are zero, and 0x7E00 when they are nonzero. A NaN therefore never becomes infinity.
- R5: A normal input whose rebiased exponent (exponent − 112) is 31 or more gives magnitude 0x7C00.
- R6: For a rebiased exponent from 1 to 30, the unrounded result has exponent field (bits 14:10) equal to the rebiased exponent and mantissa field (bits 9:0) equal to input bits 22:13.
- R7: With `rnd_mode` = 0 on that normal path, the packed magnitude is incremented exactly when input bit 12 is 1.
- R8: With `rnd_mode` = 1 on that normal path, the magnitude is incremented when input bits 12:0 exceed 0x1000, or when they equal 0x1000 and the unrounded result is odd.
- R9: For a rebiased exponent of 0 or less, let shift = 14 − rebiased exponent. The 24-bit significand (mantissa with a leading 1) is shifted right by that amount to give a subnormal mantissa with exponent field 0. A shift above 24 gives magnitude 0.
- R10: On the subnormal path, mode 0 increments when the highest discarded bit is 1. Mode 1 increments when the discarded bits exceed one half, or equal one half and the kept result is odd.
- R11: The rounding increment is applied to the packed 15-bit magnitude with no correction afterwards. Input 0x387FFFFF therefore gives 0x0400, and input 0x477FF000 gives 0x7C00 in both modes.
- R12: In mode 1, input 0x40001000 gives 0x4000 and input 0x33000000 gives 0x0000. In mode 0, 0x33000000 gives 0x0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word present this cycle |
| in_data | input | 32 | binary32 word to convert |
| rnd_mode | input | 1 | 0 = round half-up, 1 = round to nearest, ties to even |
| out_valid | output | 1 | Converted word present this cycle |
| out_data | output | 16 | binary16 result |

## Verification
The bench builds the block with its default parameters: 8/23-bit input fields, 5/10-bit output fields, and the ties-to-even variant included. At these sizes the exponent range near every class boundary can be swept exhaustively. Every exponent from 100 to 145 is swept, plus the special exponents 0, 1, 255 and a few far outliers, in both modes and with alternating sign. Each exponent gets fixed mantissas that sit on, just above and just below the rounding point, together with random mantissas. This reaches every class change, the subnormal shift limit and both carry-ripple cases. Expected words come from an integer quotient-and-remainder model in the bench.

// File: rtl/f2h_pkg.sv
package f2h_pkg;
   // Class of an input word, decided from its exponent field
   typedef enum logic [2:0] {
      CLS_ZERO,    // exponent field zero: zero or binary32 subnormal
      CLS_INFNAN,  // exponent field all ones
      CLS_OVF,     // too large for the output format
      CLS_NORM,    // lands on an output normal
      CLS_SUB,     // lands on an output subnormal
      CLS_TINY     // shifted out entirely
   } f2h_cls_e;
endpackage

// File: rtl/f2h_classify.sv
module f2h_classify
   import f2h_pkg::*;
#(
   parameter int IN_EXP_W  = 8,
   parameter int IN_MAN_W  = 23,
   parameter int OUT_EXP_W = 5,
   parameter int OUT_MAN_W = 10,
   parameter int SH_W      = 5
) (
   input  logic [IN_EXP_W-1:0]  in_exp,
   output f2h_cls_e             cls,
   output logic [OUT_EXP_W-1:0] norm_exp,
   output logic [SH_W-1:0]      sub_shift
);
   localparam int IN_BIAS  = (1 << (IN_EXP_W - 1)) - 1;
   localparam int OUT_BIAS = (1 << (OUT_EXP_W - 1)) - 1;
   localparam int OUT_MAX  = (1 << OUT_EXP_W) - 1;
   localparam int DROP     = IN_MAN_W - OUT_MAN_W;
   localparam int SH_LIMIT = IN_MAN_W + 1;
   localparam logic [IN_EXP_W-1:0] EXP_ONES = '1;

   int rebiased;
   int shift_amt;

   always_comb begin
      rebiased  = int'(in_exp) - IN_BIAS + OUT_BIAS;
      shift_amt = DROP + 1 - rebiased;
      norm_exp  = '0;
      sub_shift = '0;
      if (in_exp == '0) begin
         cls = CLS_ZERO;
      end else if (in_exp == EXP_ONES) begin
         cls = CLS_INFNAN;
      end else if (rebiased >= OUT_MAX) begin
         cls = CLS_OVF;
      end else if (rebiased >= 1) begin
         cls      = CLS_NORM;
         norm_exp = OUT_EXP_W'(rebiased);
      end else if (shift_amt > SH_LIMIT) begin
         cls = CLS_TINY;
      end else begin
         cls       = CLS_SUB;
         sub_shift = SH_W'(shift_amt);
      end
   end
endmodule

// File: rtl/f2h_round.sv
module f2h_round #(
   parameter int IN_MAN_W    = 23,
   parameter int OUT_EXP_W   = 5,
   parameter int OUT_MAN_W   = 10,
   parameter int SH_W        = 5,
   parameter bit TIE_EVEN_EN = 1'b1
) (
   input  logic [IN_MAN_W-1:0]            man,
   input  logic [OUT_EXP_W-1:0]           norm_exp,
   input  logic [SH_W-1:0]                sub_shift,
   input  logic                           use_sub,
   input  logic                           tie_even,
   output logic [OUT_EXP_W+OUT_MAN_W-1:0] mag
);
   localparam int DROP   = IN_MAN_W - OUT_MAN_W;
   localparam int SIG_W  = IN_MAN_W + 1;
   localparam int WIDE_W = 2 * SIG_W;
   localparam int MAG_W  = OUT_EXP_W + OUT_MAN_W;

   logic [SIG_W-1:0]  sig;
   logic [WIDE_W-1:0] wide;
   logic [MAG_W-1:0]  trunc;
   logic              rbit;
   logic              sticky;
   logic              inc;

   // Subnormal path: significand parked in the upper half, shifted down,
   // so the lower half holds exactly the discarded bits.
   always_comb begin
      sig  = {1'b1, man};
      wide = {sig, {SIG_W{1'b0}}} >> sub_shift;
      if (use_sub) begin
         trunc  = {{OUT_EXP_W{1'b0}}, OUT_MAN_W'(wide >> SIG_W)};
         rbit   = wide[SIG_W-1];
         sticky = |wide[SIG_W-2:0];
      end else begin
         trunc  = {norm_exp, man[IN_MAN_W-1 -: OUT_MAN_W]};
         rbit   = man[DROP-1];
         sticky = |man[DROP-2:0];
      end
   end

   generate
      if (TIE_EVEN_EN) begin : g_two_modes
         assign inc = rbit & (~tie_even | sticky | trunc[0]);
      end else begin : g_half_up_only
         logic unused_mode;
         assign unused_mode = tie_even ^ sticky;
         assign inc = rbit;
      end
   endgenerate

   // Increment on the packed field: a carry may enter the exponent
   assign mag = trunc + MAG_W'(inc);
endmodule

// File: rtl/f2h_pack.sv
module f2h_pack
   import f2h_pkg::*;
#(
   parameter int OUT_EXP_W = 5,
   parameter int OUT_MAN_W = 10
) (
   input  f2h_cls_e                       cls,
   input  logic                           sign,
   input  logic                           man_nz,
   input  logic [OUT_EXP_W+OUT_MAN_W-1:0] rounded,
   output logic [OUT_EXP_W+OUT_MAN_W:0]   word
);
   localparam int MAG_W = OUT_EXP_W + OUT_MAN_W;
   localparam logic [MAG_W-1:0] INF_MAG  = {{OUT_EXP_W{1'b1}}, {OUT_MAN_W{1'b0}}};
   localparam logic [MAG_W-1:0] QNAN_MAG = INF_MAG | (MAG_W'(1) << (OUT_MAN_W - 1));

   logic [MAG_W-1:0] mag;

   always_comb begin
      case (cls)
         CLS_INFNAN:        mag = man_nz ? QNAN_MAG : INF_MAG;
         CLS_OVF:           mag = INF_MAG;
         CLS_NORM, CLS_SUB: mag = rounded;
         default:           mag = '0;
      endcase
      word = {sign, mag};
   end
endmodule

// File: rtl/fp32_to_fp16_cvt.sv
module fp32_to_fp16_cvt
   import f2h_pkg::*;
#(
   parameter int IN_EXP_W    = 8,
   parameter int IN_MAN_W    = 23,
   parameter int OUT_EXP_W   = 5,
   parameter int OUT_MAN_W   = 10,
   parameter bit TIE_EVEN_EN = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic [IN_EXP_W+IN_MAN_W:0]    in_data,
   input  logic                          rnd_mode,
   output logic                          out_valid,
   output logic [OUT_EXP_W+OUT_MAN_W:0]  out_data
);
   localparam int IW   = IN_EXP_W + IN_MAN_W + 1;
   localparam int OW   = OUT_EXP_W + OUT_MAN_W + 1;
   localparam int SH_W = $clog2(IN_MAN_W + 2);

   // Elaboration-time parameter checks
   generate
      if (OUT_EXP_W >= IN_EXP_W) begin : g_bad_exp
         $error("output exponent must be narrower than input exponent");
      end
      if (IN_MAN_W - OUT_MAN_W < 2) begin : g_bad_man
         $error("at least two mantissa bits must be dropped");
      end
      if (OUT_EXP_W < 2 || OUT_MAN_W < 1) begin : g_bad_out
         $error("output format too small");
      end
   endgenerate

   logic                  sign;
   logic [IN_EXP_W-1:0]   exp_f;
   logic [IN_MAN_W-1:0]   man_f;
   f2h_cls_e              cls;
   logic [OUT_EXP_W-1:0]  norm_exp;
   logic [SH_W-1:0]       sub_shift;
   logic [OW-2:0]         rounded;
   logic [OW-1:0]         result;

   assign sign  = in_data[IW-1];
   assign exp_f = in_data[IW-2 -: IN_EXP_W];
   assign man_f = in_data[IN_MAN_W-1:0];

   f2h_classify #(
      .IN_EXP_W (IN_EXP_W),
      .IN_MAN_W (IN_MAN_W),
      .OUT_EXP_W(OUT_EXP_W),
      .OUT_MAN_W(OUT_MAN_W),
      .SH_W     (SH_W)
   ) u_classify (
      .in_exp   (exp_f),
      .cls      (cls),
      .norm_exp (norm_exp),
      .sub_shift(sub_shift)
   );

   f2h_round #(
      .IN_MAN_W   (IN_MAN_W),
      .OUT_EXP_W  (OUT_EXP_W),
      .OUT_MAN_W  (OUT_MAN_W),
      .SH_W       (SH_W),
      .TIE_EVEN_EN(TIE_EVEN_EN)
   ) u_round (
      .man      (man_f),
      .norm_exp (norm_exp),
      .sub_shift(sub_shift),
      .use_sub  (cls == CLS_SUB),
      .tie_even (rnd_mode),
      .mag      (rounded)
   );

   f2h_pack #(
      .OUT_EXP_W(OUT_EXP_W),
      .OUT_MAN_W(OUT_MAN_W)
   ) u_pack (
      .cls    (cls),
      .sign   (sign),
      .man_nz (|man_f),
      .rounded(rounded),
      .word   (result)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= result;
      end
   end
endmodule

// File: rtl/fp32_to_fp16_cvt_chk.sv
module fp32_to_fp16_cvt_chk #(
   parameter int IN_EXP_W  = 8,
   parameter int IN_MAN_W  = 23,
   parameter int OUT_EXP_W = 5,
   parameter int OUT_MAN_W = 10
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         in_valid,
   input logic [IN_EXP_W+IN_MAN_W:0]   in_data,
   input logic                         out_valid,
   input logic [OUT_EXP_W+OUT_MAN_W:0] out_data
);
   localparam int IW      = IN_EXP_W + IN_MAN_W + 1;
   localparam int OW      = OUT_EXP_W + OUT_MAN_W + 1;
   localparam int MAG_W   = OW - 1;
   localparam int OVF_EXP = ((1 << (IN_EXP_W - 1)) - 1) - ((1 << (OUT_EXP_W - 1)) - 1)
                            + ((1 << OUT_EXP_W) - 1);
   localparam logic [MAG_W-1:0] INF_MAG  = {{OUT_EXP_W{1'b1}}, {OUT_MAN_W{1'b0}}};
   localparam logic [MAG_W-1:0] QNAN_MAG = INF_MAG | (MAG_W'(1) << (OUT_MAN_W - 1));
   localparam logic [IN_EXP_W-1:0] EXP_ONES = '1;

   logic [IN_EXP_W-1:0] c_exp;
   logic                c_man_nz;
   logic [MAG_W-1:0]    c_mag;

   assign c_exp    = in_data[IW-2 -: IN_EXP_W];
   assign c_man_nz = |in_data[IN_MAN_W-1:0];
   assign c_mag    = out_data[MAG_W-1:0];

   assert_valid_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_data)));
   assert_sign_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_data[OW-1] == $past(in_data[IW-1]));
   assert_zero_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && c_exp == '0) |=> c_mag == '0);
   assert_inf_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && c_exp == EXP_ONES && !c_man_nz) |=> c_mag == INF_MAG);
   assert_nan_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && c_exp == EXP_ONES && c_man_nz) |=> c_mag == QNAN_MAG);
   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && c_exp != EXP_ONES && int'(c_exp) >= OVF_EXP) |=> c_mag == INF_MAG);
endmodule

bind fp32_to_fp16_cvt fp32_to_fp16_cvt_chk #(
   .IN_EXP_W (IN_EXP_W),
   .IN_MAN_W (IN_MAN_W),
   .OUT_EXP_W(OUT_EXP_W),
   .OUT_MAN_W(OUT_MAN_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_data  (in_data),
   .out_valid(out_valid),
   .out_data (out_data)
);

// File: tb/test_fp32_to_fp16_cvt.sv
`timescale 1ns/1ps
module test_fp32_to_fp16_cvt;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        rnd_mode = 1'b0;
   logic        out_valid;
   logic [15:0] out_data;

   int errors = 0;
   int checks = 0;

   logic        pend_v = 1'b0;
   logic [15:0] pend_d = '0;
   logic [15:0] held = '0;
   string       pend_tag = "R1";

   always #2.5 clk = ~clk;

   fp32_to_fp16_cvt i_fp32_to_fp16_cvt (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .rnd_mode(rnd_mode), .out_valid(out_valid), .out_data(out_data)
   );

   // Arithmetic model: quotient and remainder of the significand in units of
   // the target spacing; packed = (E-1)*1024 + quotient + roundup.
   function automatic logic [15:0] model(input logic [31:0] x, input logic m);
      int          e;
      int          te;
      int          s;
      longint      sig;
      longint      q;
      longint      rem;
      longint      half;
      logic        up;
      logic [14:0] mag;
      e   = int'(x[30:23]);
      sig = longint'(x[22:0]) + 64'd8388608;
      if (e == 0) mag = 15'h0;
      else if (e == 255) mag = (x[22:0] != 0) ? 15'h7E00 : 15'h7C00;
      else if (e - 112 >= 31) mag = 15'h7C00;
      else begin
         te = (e - 112 < 1) ? 1 : e - 112;
         s  = te - e + 125;
         if (s > 25) mag = 15'h0;
         else begin
            q    = sig >> s;
            rem  = sig - (q << s);
            half = 64'd1 << (s - 1);
            up   = m ? ((rem > half) || (rem == half && q[0])) : (rem >= half);
            mag  = 15'(longint'(te - 1) * 1024 + q + longint'(up));
         end
      end
      return {x[31], mag};
   endfunction

   function automatic string tag_of(input logic [31:0] x, input logic m);
      int e;
      e = int'(x[30:23]);
      if (e == 0) return "R3";
      if (e == 255) return "R4";
      if (e >= 143) return "R5";
      if (e >= 113) return m ? "R8" : "R7";
      if (e >= 102) return "R10";
      return "R9";
   endfunction

   task automatic check_out();
      checks++;
      if (out_valid !== pend_v) begin
         errors++;
         $display("FAIL R1: out_valid got %0b expected %0b", out_valid, pend_v);
      end
      if (pend_v) begin
         checks++;
         if (out_data[15] !== pend_d[15]) begin
            errors++;
            $display("FAIL R2: sign got %0b expected %0b", out_data[15], pend_d[15]);
         end
         checks++;
         if (out_data !== pend_d) begin
            errors++;
            $display("FAIL %s: out_data got %h expected %h (in %h mode %0b)",
                     pend_tag, out_data, pend_d, in_data, rnd_mode);
         end
         held = pend_d;
      end else begin
         checks++;
         if (out_data !== held) begin
            errors++;
            $display("FAIL R1: held out_data got %h expected %h", out_data, held);
         end
      end
   endtask

   task automatic cycle(input logic v, input logic [31:0] d, input logic m,
                        input logic [15:0] e, input string tag);
      @(negedge clk);
      check_out();
      in_valid = v;
      in_data  = d;
      rnd_mode = m;
      pend_v   = v;
      pend_d   = e;
      pend_tag = v ? tag : "R1";
   endtask

   task automatic push(input logic [31:0] d, input logic m);
      cycle(1'b1, d, m, model(d, m), tag_of(d, m));
   endtask

   initial begin
      #1_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, got hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int exps[$];
      logic [22:0] fixed_m[6];
      int n;
      fixed_m = '{23'h000000, 23'h7FFFFF, 23'h001000, 23'h003000, 23'h000FFF, 23'h001001};

      // R1 reset state
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_data !== 16'h0) begin
         errors++;
         $display("FAIL R1: reset state got %0b/%h expected 0/0000", out_valid, out_data);
      end
      rst_n = 1'b1;

      // Directed cases
      cycle(1'b1, 32'h3F800000, 1'b0, 16'h3C00, "R6");
      cycle(1'b1, 32'hBF800000, 1'b1, 16'hBC00, "R6");
      cycle(1'b0, 32'h0, 1'b0, 16'h0, "R1");
      cycle(1'b0, 32'h7F800000, 1'b1, 16'h0, "R1");
      cycle(1'b1, 32'h387FFFFF, 1'b0, 16'h0400, "R11");
      cycle(1'b1, 32'h387FFFFF, 1'b1, 16'h0400, "R11");
      cycle(1'b1, 32'h477FF000, 1'b0, 16'h7C00, "R11");
      cycle(1'b1, 32'h477FF000, 1'b1, 16'h7C00, "R11");
      cycle(1'b1, 32'h40001000, 1'b1, 16'h4000, "R12");
      cycle(1'b1, 32'h40001000, 1'b0, 16'h4001, "R7");
      cycle(1'b1, 32'h33000000, 1'b1, 16'h0000, "R12");
      cycle(1'b1, 32'h33000000, 1'b0, 16'h0001, "R12");
      cycle(1'b1, 32'hB2800000, 1'b0, 16'h8000, "R9");
      cycle(1'b1, 32'hFFC00001, 1'b0, 16'hFE00, "R4");
      cycle(1'b1, 32'h7F800001, 1'b1, 16'h7E00, "R4");
      cycle(1'b1, 32'h80000001, 1'b0, 16'h8000, "R3");
      cycle(1'b1, 32'h3F801000, 1'b1, 16'h3C00, "R8");
      cycle(1'b1, 32'h3F803000, 1'b1, 16'h3C02, "R8");

      // Sweep: special and far exponents plus every exponent 100..145
      exps = '{0, 1, 50, 200, 254, 255};
      for (int e = 100; e <= 145; e++) exps.push_back(e);
      n = 0;
      foreach (exps[k]) begin
         for (int md = 0; md < 2; md++) begin
            for (int j = 0; j < 26; j++) begin
               logic [22:0] mm;
               logic [31:0] w;
               mm = (j < 6) ? fixed_m[j] : 23'($urandom);
               w  = {1'(n), 8'(exps[k]), mm};
               push(w, 1'(md));
               n++;
               if (n % 9 == 0) cycle(1'b0, 32'hDEADBEEF, 1'b1, 16'h0, "R1");
            end
         end
      end
      cycle(1'b0, 32'h0, 1'b0, 16'h0, "R1");
      cycle(1'b0, 32'h0, 1'b0, 16'h0, "R1");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule